// File: doc/BRIEF.md
# Two-Way Parallel Two-Tap Summer

This block forms the running pairwise sum y[n] = x[n] + x[n-1] over a serial stream of unsigned samples. It does the work two samples at a time, so each adder evaluates once per pair of input samples rather than once per sample. That is the effect of running the core at half the sample rate. Samples arrive one per accepted transfer on a single clock. A phase counter steers them alternately into the older lane and the newer lane. When the newer sample of a pair is accepted, both sums are registered together and shown as one two-lane output word.

The older lane's sum needs the sample before it, and that sample belongs to the previous pair. A one-sample history register keeps the newer sample of each completed pair so the next pair can use it. Both stream edges use valid/ready. Input transfers happen when `in_valid` and `in_ready` are both high. Output transfers happen when `out_valid` and `out_ready` are both high. The output stage is a single register. A held output therefore blocks only the sample that would complete the next pair. The sample that opens the next pair is still accepted.

Top module: `pts_pair_summer`

## Requirements
- R1: Each output lane equals its own sample plus the sample accepted just before it, as an unsigned sum of SAMPLE_W+1 bits (6 bits by default).
- R2: After reset the held previous sample is zero, so lane 0 of the first output equals the first accepted sample.
- R3: Accepted samples are grouped in pairs in arrival order. `out_sum[5:0]` carries the sum for the older sample of the pair, and `out_sum[11:6]` carries the sum for the newer one.
- R4: The delayed operand of lane 0 is the newer sample of the previously completed pair.
- R5: `out_valid` rises in the clock cycle after the newer sample of a pair is accepted. Accepting only the older sample leaves the output untouched.
- R6: A cycle with `in_valid` low captures nothing. The partial pair and the history are kept, whatever value `in_data` has.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_sum` hold steady. `in_ready` is low only when the older sample of a pair is already held and the output is still unconsumed.
- R8: After an output handshake with no new pair completing, `out_valid` goes low in the next cycle.
- R9: The largest inputs, 31 + 31, give exactly 62 with no wrap.
- R10: Reset discards a partial pair and clears the history. The first pair after reset then starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample is offered |
| in_ready | output | 1 | Block can take the offered sample |
| in_data | input | SAMPLE_W (5) | Unsigned input sample |
| out_valid | output | 1 | Output pair word is valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_sum | output | LANES*(SAMPLE_W+1) (12) | Lane sums, oldest lane in the low bits |

## Verification
Several rules are checked by assertions on every cycle. These are output stability under back-pressure, that `out_valid` rises only after an accepted input and falls only after a handshake, that the phase wraps after the last lane and does not move on idle cycles, and the order relations between the lane sums and the history register. Exact arithmetic can only be shown by the bench scenarios. This covers the zero history after reset, the cross-pair operand, the saturating-free maximum and recovery from a reset in the middle of a pair. The bench compares a fixed vector table and a long random stream with random gaps and random back-pressure against a serial reference.

// File: rtl/pts_pkg.sv
package pts_pkg;

  // Width of an unsigned sum of two samples of the given width.
  function automatic int sum_width(input int sample_w);
    return sample_w + 1;
  endfunction

  // Width of a lane index for a given number of lanes.
  function automatic int index_width(input int lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction

endpackage

// File: rtl/pts_lane_capture.sv
module pts_lane_capture
  import pts_pkg::*;
#(
  parameter int SAMPLE_W = 5,
  parameter int LANES    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         accept,
  input  logic [SAMPLE_W-1:0]          in_data,
  output logic [LANES*SAMPLE_W-1:0]    lanes,
  output logic                         last_slot,
  output logic                         complete
);

  localparam int IDX_W = index_width(LANES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

  logic [IDX_W-1:0] phase_q;

  assign last_slot = (phase_q == LAST_IDX);
  assign complete  = accept && last_slot;

  // Phase counter picks the lane that the next accepted sample fills.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (accept) begin
      if (last_slot) phase_q <= '0;
      else           phase_q <= phase_q + 1'b1;
    end
  end

  // Older lanes are registered; the newest lane is taken straight from the input.
  for (genvar i = 0; i < LANES - 1; i++) begin : g_slot
    logic [SAMPLE_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (accept && (phase_q == IDX_W'(i))) begin
        slot_q <= in_data;
      end
    end
    assign lanes[i*SAMPLE_W +: SAMPLE_W] = slot_q;
  end

  assign lanes[(LANES-1)*SAMPLE_W +: SAMPLE_W] = in_data;

  // R3
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last_slot) |=> (phase_q == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(phase_q));

endmodule

// File: rtl/pts_lane_adders.sv
module pts_lane_adders
  import pts_pkg::*;
#(
  parameter int SAMPLE_W = 5,
  parameter int LANES    = 2
) (
  input  logic [LANES*SAMPLE_W-1:0]           lanes,
  input  logic [SAMPLE_W-1:0]                 history,
  output logic [LANES*sum_width(SAMPLE_W)-1:0] sums
);

  localparam int SUM_W = sum_width(SAMPLE_W);

  // Lane i adds its own sample to lane i-1; lane 0 borrows the history sample.
  for (genvar i = 0; i < LANES; i++) begin : g_add
    logic [SAMPLE_W-1:0] cur;
    logic [SAMPLE_W-1:0] prev;
    assign cur = lanes[i*SAMPLE_W +: SAMPLE_W];
    if (i == 0) begin : g_first
      assign prev = history;
    end else begin : g_rest
      assign prev = lanes[(i-1)*SAMPLE_W +: SAMPLE_W];
    end
    assign sums[i*SUM_W +: SUM_W] = {1'b0, cur} + {1'b0, prev};
  end

endmodule

// File: rtl/pts_pair_summer.sv
module pts_pair_summer
  import pts_pkg::*;
#(
  parameter int SAMPLE_W = 5,
  parameter int LANES    = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  input  logic [SAMPLE_W-1:0]                    in_data,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic [LANES*sum_width(SAMPLE_W)-1:0]   out_sum
);

  localparam int SUM_W   = sum_width(SAMPLE_W);
  localparam int LAST_LO = (LANES - 1) * SUM_W;

  logic                          accept;
  logic                          last_slot;
  logic                          complete;
  logic [LANES*SAMPLE_W-1:0]     lanes;
  logic [LANES*SUM_W-1:0]        sums;
  logic [SAMPLE_W-1:0]           hold_q;
  logic [LANES*SUM_W-1:0]        out_sum_q;
  logic                          out_valid_q;

  // Only the pair-completing sample needs a free output register.
  assign in_ready = !last_slot || !out_valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  pts_lane_capture #(
    .SAMPLE_W (SAMPLE_W),
    .LANES    (LANES)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .in_data   (in_data),
    .lanes     (lanes),
    .last_slot (last_slot),
    .complete  (complete)
  );

  pts_lane_adders #(
    .SAMPLE_W (SAMPLE_W),
    .LANES    (LANES)
  ) u_adders (
    .lanes   (lanes),
    .history (hold_q),
    .sums    (sums)
  );

  // History: newest sample of the last completed pair.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (complete) begin
      hold_q <= in_data;
    end
  end

  // One-deep output register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sum_q   <= '0;
      out_valid_q <= 1'b0;
    end else if (complete) begin
      out_sum_q   <= sums;
      out_valid_q <= 1'b1;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_sum   = out_sum_q;
  assign out_valid = out_valid_q;

  // R7
  backpressure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  // R5
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R8
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  // R4
  cross_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> ({1'b0, $past(hold_q)} <= out_sum_q[SUM_W-1:0]));

  // R1
  newest_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> ({1'b0, hold_q} <= out_sum_q[LAST_LO +: SUM_W]));

endmodule

// File: tb/pts_pair_summer_test.sv
`timescale 1ns/1ps
module pts_pair_summer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_sum;

  always #4 clk = ~clk;

  pts_pair_summer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sum   (out_sum)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Vectors: {older sample, newer sample, newer-lane sum, older-lane sum}
  localparam logic [21:0] VEC [4] = '{
    {5'd3,  5'd7,  6'd10, 6'd3 },
    {5'd31, 5'd31, 6'd62, 6'd38},
    {5'd0,  5'd31, 6'd31, 6'd31},
    {5'd12, 5'd5,  6'd17, 6'd43}
  };

  // Serial reference model
  int          ref_prev = 0;
  bit          ref_ph = 1'b0;
  int          ref_y0 = 0;
  bit          mon_en = 1'b0;
  bit          rand_rdy = 1'b0;
  logic [11:0] exp_mem [0:1023];
  int          wr = 0;
  int          rd = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ref_reset();
    ref_prev = 0;
    ref_ph = 1'b0;
  endtask

  task automatic ref_accept(input logic [4:0] s);
    int y;
    y = int'(s) + ref_prev;
    ref_prev = int'(s);
    if (!ref_ph) begin
      ref_y0 = y;
      ref_ph = 1'b1;
    end else begin
      if (mon_en) begin
        exp_mem[wr] = {6'(y), 6'(ref_y0)};
        wr++;
      end
      ref_ph = 1'b0;
    end
  endtask

  task automatic send(input logic [4:0] s);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = s;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    ref_accept(s);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // Output monitor against the serial reference
  always @(negedge clk) begin
    #1;
    if (mon_en && rst_n && out_valid && out_ready) begin
      if (rd < wr) begin
        chk("R1 R3 R4 R6 stream", 32'(out_sum), 32'(exp_mem[rd]));
        rd++;
      end else begin
        chk("R5 unexpected output", 32'(out_valid), 32'd0);
      end
    end
  end

  // Random consumer back-pressure
  always @(negedge clk) begin
    if (rand_rdy) out_ready = ($urandom % 3) != 0;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] snap;
    ref_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10 reset out_valid", 32'(out_valid), 32'd0);
    chk("R10 reset in_ready", 32'(in_ready), 32'd1);

    // Vector table, R2 on the first pair
    for (int k = 0; k < 4; k++) begin
      send(VEC[k][21:17]);
      @(negedge clk); #1;
      chk("R5 no output after older sample", 32'(out_valid), 32'd0);
      send(VEC[k][16:12]);
      @(negedge clk); #1;
      chk("R5 output after newer sample", 32'(out_valid), 32'd1);
      chk("R1/R2/R3/R4/R9 vector", 32'(out_sum), 32'(VEC[k][11:0]));
    end

    // R6 idle gap with changing data: history is 5
    send(5'd20);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_data = 5'd31;
      #1;
      chk("R6 idle no output", 32'(out_valid), 32'd0);
    end
    send(5'd2);
    @(negedge clk); #1;
    chk("R6 sums after gap", 32'(out_sum), 32'({6'd22, 6'd25}));

    // R8 clears after handshake
    @(negedge clk); #1;
    chk("R8 valid cleared", 32'(out_valid), 32'd0);

    // R7 back-pressure
    mon_en = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    send(5'd9);
    send(5'd14);
    send(5'd6);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 5'd1;
    #1;
    chk("R7 in_ready low on blocked completion", 32'(in_ready), 32'd0);
    snap = out_sum;
    repeat (3) @(negedge clk);
    #1;
    chk("R7 valid held", 32'(out_valid), 32'd1);
    chk("R7 sum held", 32'(out_sum), 32'(snap));
    chk("R7 sum value", 32'(out_sum), 32'({6'd23, 6'd11}));
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    send(5'd1);
    repeat (3) @(negedge clk);

    // R10 reset in the middle of a pair
    send(5'd17);
    @(negedge clk);
    rst_n = 1'b0;
    ref_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 valid after reset", 32'(out_valid), 32'd0);
    send(5'd4);
    send(5'd6);
    @(negedge clk); #1;
    chk("R10 pair after reset", 32'(out_sum), 32'({6'd10, 6'd4}));
    repeat (2) @(negedge clk);

    // Random stream with gaps and back-pressure
    rand_rdy = 1'b1;
    for (int k = 0; k < 400; k++) begin
      int gap;
      gap = $urandom % 3;
      repeat (gap) @(negedge clk);
      send(5'($urandom));
    end
    @(negedge clk);
    rand_rdy  = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 all outputs delivered", 32'(rd), 32'(wr));
    chk("R8 idle after drain", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule